// File: doc/BRIEF.md
# ATA Strobe Cycle Timing Generator

This block produces the read/write strobe for parallel ATA programmed-I/O and multiword-DMA bus cycles. Each of two attached devices owns a timing word that packs an access count and a recovery count for each cycle kind, a half-tick flag for DMA and an extension flag for the slowest PIO mode. A device select copies the chosen device's word into the active timing register. Each cycle request then raises the strobe for the access time, drops it for the recovery time, and pulses a completion flag.

The block runs on a clock at twice the tick rate, so one 30 ns timing tick is two clock periods and a half tick is exactly one clock. A nanosecond requirement becomes a tick count by ceiling division by 30. The timing word stored for each device is the 22 meaningful low bits of the controller's 32-bit timing word. A request that arrives while a cycle is running is held and starts as soon as the running cycle's recovery ends.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, and on the clock after `wake_i` is high, both device slots and the active word hold 0x074526 (PIO 76/82 clocks, DMA 16/14 clocks). The strobe, `busy_o` and `done_o` are low, and any cycle in progress or held request is dropped.
- R2: One tick equals two clocks. For a PIO cycle (`dma_i`=0) the strobe is high for 2×word[4:0] clocks and then low for 2×word[9:5] clocks.
- R3: For a DMA cycle (`dma_i`=1) the access count is word[15:11] and the recovery count is word[20:16], each in ticks.
- R4: When word[21] is set, a DMA access lasts one extra clock (half a tick) and the DMA recovery is one tick shorter, never below one tick. The bit has no effect on PIO cycles.
- R5: When word[10] is set, 32 ticks are added to both the PIO access count and the PIO recovery count. The bit has no effect on DMA cycles.
- R6: A count that works out to zero is used as one tick, so each strobe phase lasts at least two clocks.
- R7: A select (`sel_i`) loads the active word from the slot of `sel_dev_i`. If a write to that slot happens in the same clock, the newly written word is loaded. A write without a select leaves the active word unchanged.
- R8: A cycle's access and recovery lengths are fixed when the cycle starts. A select during the cycle does not change them.
- R9: A request accepted while idle raises the strobe on the next clock edge. `done_o` is a one-clock pulse on the clock after the last recovery clock. `busy_o` is high while a cycle runs or a request is held.
- R10: One request that arrives during a running cycle is held, together with its cycle kind. It starts on the same edge that raises `done_o`. Further requests made while one is already held are merged into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the tick rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | Reload default timing words and abort activity |
| cfg_we_i | input | 1 | Write strobe for a device timing word |
| cfg_dev_i | input | 1 | Device slot to write |
| cfg_word_i | input | 22 | Timing word to store |
| sel_i | input | 1 | Device select: load the active word |
| sel_dev_i | input | 1 | Device being selected |
| req_i | input | 1 | Cycle request |
| dma_i | input | 1 | Cycle kind of the request: 1 = DMA, 0 = PIO |
| strobe_o | output | 1 | Bus strobe, high during the access phase |
| busy_o | output | 1 | Cycle running or request held |
| done_o | output | 1 | One-clock pulse at the end of recovery |

## Verification
A wrong active word, a badly decoded field or a lost half-tick shows up directly in the strobe: the length of the high or low phase is off by some clocks. This is seen within the first cycle after the faulty select. A corrupted held request or counter shows up as a missing, early or doubled `done_o`, or as a strobe that does not rise on the edge of the completion pulse. The bench therefore measures every high and low run to the exact clock and checks where the completion pulse falls relative to the strobe.

// File: rtl/ats_pkg.sv
package ats_pkg;
    localparam int NUM_DEV     = 2;
    localparam int DEV_W       = $clog2(NUM_DEV);
    localparam int FIELD_W     = 5;
    localparam int EXT_TICKS   = 32;
    localparam int WORD_W      = 22;
    localparam int PIO_ACC_LSB = 0;
    localparam int PIO_REC_LSB = 5;
    localparam int EXT_BIT     = 10;
    localparam int DMA_ACC_LSB = 11;
    localparam int DMA_REC_LSB = 16;
    localparam int HALF_BIT    = 21;
    localparam int MAX_TICKS   = (1 << FIELD_W) - 1 + EXT_TICKS;
    localparam int CNT_W       = $clog2(2 * MAX_TICKS + 2);
    localparam logic [WORD_W-1:0] DEFAULT_WORD = 22'h074526;

    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ACC = 2'd1, PH_REC = 2'd2} phase_e;

    typedef struct packed {
        logic [NUM_DEV-1:0][WORD_W-1:0] slot;
        logic [WORD_W-1:0]              active;
    } store_s;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rec;
        logic             pend;
        logic             pend_dma;
        logic             done;
    } seq_s;
endpackage

// File: rtl/ats_word_store.sv
module ats_word_store
    import ats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              cfg_we_i,
    input  logic [DEV_W-1:0]  cfg_dev_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic              sel_i,
    input  logic [DEV_W-1:0]  sel_dev_i,
    output logic [WORD_W-1:0] active_o
);
    store_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) st_d.slot[cfg_dev_i] = cfg_word_i;
        if (sel_i)    st_d.active = st_d.slot[sel_dev_i];
        if (wake_i) begin
            for (int i = 0; i < NUM_DEV; i++) st_d.slot[i] = DEFAULT_WORD;
            st_d.active = DEFAULT_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DEV; i++) st_q.slot[i] <= DEFAULT_WORD;
            st_q.active <= DEFAULT_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !wake_i) |=> $stable(active_o)); // R7
    AST_WAKE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> (active_o == DEFAULT_WORD)); // R1
endmodule

// File: rtl/ats_phase_calc.sv
module ats_phase_calc
    import ats_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              dma_i,
    output logic [CNT_W-1:0]  acc_clks_o,
    output logic [CNT_W-1:0]  rec_clks_o
);
    logic [CNT_W-1:0] acc_t, rec_t;
    logic             half;

    always_comb begin
        half = 1'b0;
        if (dma_i) begin
            acc_t = CNT_W'(word_i[DMA_ACC_LSB +: FIELD_W]);
            rec_t = CNT_W'(word_i[DMA_REC_LSB +: FIELD_W]);
            half  = word_i[HALF_BIT];
            if (half) rec_t = (rec_t <= CNT_W'(1)) ? CNT_W'(1) : rec_t - CNT_W'(1);
        end else begin
            acc_t = CNT_W'(word_i[PIO_ACC_LSB +: FIELD_W]);
            rec_t = CNT_W'(word_i[PIO_REC_LSB +: FIELD_W]);
            if (word_i[EXT_BIT]) begin
                acc_t = acc_t + CNT_W'(EXT_TICKS);
                rec_t = rec_t + CNT_W'(EXT_TICKS);
            end
        end
        if (acc_t == '0) acc_t = CNT_W'(1);
        if (rec_t == '0) rec_t = CNT_W'(1);
        acc_clks_o = (acc_t << 1) + CNT_W'(half);
        rec_clks_o = rec_t << 1;
    end
endmodule

// File: rtl/ats_phase_seq.sv
module ats_phase_seq
    import ats_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_i,
    input  logic             req_i,
    input  logic             dma_i,
    input  logic [CNT_W-1:0] acc_clks_i,
    input  logic [CNT_W-1:0] rec_clks_i,
    output logic             start_dma_o,
    output logic             strobe_o,
    output logic             busy_o,
    output logic             done_o
);
    seq_s sq_d, sq_q;

    assign start_dma_o = sq_q.pend ? sq_q.pend_dma : dma_i;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    sq_d.ph  = PH_ACC;
                    sq_d.cnt = acc_clks_i - CNT_W'(1);
                    sq_d.rec = rec_clks_i;
                end
            end
            PH_ACC: begin
                if (req_i && !sq_q.pend) begin
                    sq_d.pend     = 1'b1;
                    sq_d.pend_dma = dma_i;
                end
                if (sq_q.cnt == '0) begin
                    sq_d.ph  = PH_REC;
                    sq_d.cnt = sq_q.rec - CNT_W'(1);
                end else begin
                    sq_d.cnt = sq_q.cnt - CNT_W'(1);
                end
            end
            PH_REC: begin
                if (sq_q.cnt == '0) begin
                    sq_d.done = 1'b1;
                    if (sq_q.pend || req_i) begin
                        sq_d.ph   = PH_ACC;
                        sq_d.cnt  = acc_clks_i - CNT_W'(1);
                        sq_d.rec  = rec_clks_i;
                        sq_d.pend = 1'b0;
                    end else begin
                        sq_d.ph = PH_IDLE;
                    end
                end else begin
                    sq_d.cnt = sq_q.cnt - CNT_W'(1);
                    if (req_i && !sq_q.pend) begin
                        sq_d.pend     = 1'b1;
                        sq_d.pend_dma = dma_i;
                    end
                end
            end
            default: sq_d.ph = PH_IDLE;
        endcase
        if (wake_i) sq_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign strobe_o = (sq_q.ph == PH_ACC);
    assign busy_o   = (sq_q.ph != PH_IDLE) || sq_q.pend;
    assign done_o   = sq_q.done;

    AST_ACC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_o) && !wake_i) |=> strobe_o); // R6
    AST_REC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe_o) && !wake_i) |=> !strobe_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_REC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sq_q.ph == PH_REC)); // R9
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy_o); // R9
    AST_HELD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.pend && sq_q.ph == PH_REC && sq_q.cnt == '0 && !wake_i) |=> (strobe_o && done_o)); // R10
endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              cfg_we_i,
    input  logic [DEV_W-1:0]  cfg_dev_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic              sel_i,
    input  logic [DEV_W-1:0]  sel_dev_i,
    input  logic              req_i,
    input  logic              dma_i,
    output logic              strobe_o,
    output logic              busy_o,
    output logic              done_o
);
    logic [WORD_W-1:0] active_word;
    logic [CNT_W-1:0]  acc_clks, rec_clks;
    logic              start_dma;

    ats_word_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_i     (wake_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_dev_i  (cfg_dev_i),
        .cfg_word_i (cfg_word_i),
        .sel_i      (sel_i),
        .sel_dev_i  (sel_dev_i),
        .active_o   (active_word)
    );

    ats_phase_calc u_calc (
        .word_i     (active_word),
        .dma_i      (start_dma),
        .acc_clks_o (acc_clks),
        .rec_clks_o (rec_clks)
    );

    ats_phase_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_i      (wake_i),
        .req_i       (req_i),
        .dma_i       (dma_i),
        .acc_clks_i  (acc_clks),
        .rec_clks_i  (rec_clks),
        .start_dma_o (start_dma),
        .strobe_o    (strobe_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );
endmodule

// File: tb/tb_ata_strobe_timer.sv
module tb_ata_strobe_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake_i = 1'b0, cfg_we_i = 1'b0, cfg_dev_i = 1'b0;
    logic [21:0] cfg_word_i = '0;
    logic        sel_i = 1'b0, sel_dev_i = 1'b0, req_i = 1'b0, dma_i = 1'b0;
    logic        strobe_o, busy_o, done_o;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    ata_strobe_timer dut (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .cfg_we_i(cfg_we_i),
        .cfg_dev_i(cfg_dev_i), .cfg_word_i(cfg_word_i), .sel_i(sel_i),
        .sel_dev_i(sel_dev_i), .req_i(req_i), .dma_i(dma_i),
        .strobe_o(strobe_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void exp_len(input logic [21:0] w, input bit dma, output int a, output int r);
        int af, rf;
        if (dma) begin
            af = int'(w[15:11]); rf = int'(w[20:16]);
            if (af == 0) af = 1;
            a = 2 * af + int'(w[21]);
            if (w[21]) rf = rf - 1;
            if (rf < 1) rf = 1;
            r = 2 * rf;
        end else begin
            af = int'(w[4:0]); rf = int'(w[9:5]);
            if (w[10]) begin af += 32; rf += 32; end
            if (af == 0) af = 1;
            if (rf == 0) rf = 1;
            a = 2 * af; r = 2 * rf;
        end
    endfunction

    task automatic write_word(input bit dev, input logic [21:0] w);
        @(negedge clk); cfg_we_i = 1'b1; cfg_dev_i = dev; cfg_word_i = w;
        @(negedge clk); cfg_we_i = 1'b0;
    endtask

    task automatic select(input bit dev);
        @(negedge clk); sel_i = 1'b1; sel_dev_i = dev;
        @(negedge clk); sel_i = 1'b0;
    endtask

    task automatic issue(input bit dma);
        @(negedge clk); req_i = 1'b1; dma_i = dma;
        @(negedge clk); req_i = 1'b0;
    endtask

    // starts at a negedge where strobe is expected high; ends at the done negedge
    task automatic measure(input int ea, input int er, input int hi0, input string tag);
        int hi = hi0, lo = 0;
        while (strobe_o && hi < 400) begin hi++; @(negedge clk); end
        while (!done_o && lo < 400) begin lo++; @(negedge clk); end
        chk(hi == ea, {tag, " access clocks"}, hi, ea);
        chk(lo == er, {tag, " recovery clocks"}, lo, er);
    endtask

    task automatic cycle(input logic [21:0] w, input bit dma, input string tag);
        int a, r;
        exp_len(w, dma, a, r);
        issue(dma);
        measure(a, r, 0, tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [21:0] w0, w1, w;
        int a, r, a2, r2, hi, lo;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!strobe_o && !busy_o && !done_o, "R1 idle after reset", {strobe_o, busy_o, done_o}, 0);
        cycle(22'h074526, 1'b0, "R1 default PIO");
        chk(!strobe_o, "R9 strobe low at done", strobe_o, 0);
        @(negedge clk);
        chk(!done_o, "R9 done one clock", done_o, 0);
        chk(!busy_o, "R9 idle after done", busy_o, 0);
        select(1'b1);
        cycle(22'h074526, 1'b1, "R1 default DMA slot1");

        // R2/R3 plain fields
        w0 = 22'((3 << 16) | (6 << 11) | (7 << 5) | 4);
        write_word(1'b0, w0); select(1'b0);
        cycle(w0, 1'b0, "R2 PIO fields");
        cycle(w0, 1'b1, "R3 DMA fields");
        // R4 half tick
        w = 22'((1 << 21) | (4 << 16) | (3 << 11));
        write_word(1'b0, w); select(1'b0);
        cycle(w, 1'b1, "R4 half-tick DMA");
        w = 22'((1 << 21) | (1 << 16));
        write_word(1'b0, w); select(1'b0);
        cycle(w, 1'b1, "R4 half-tick floor");
        // R5 extension / R4 ignored on PIO
        w = 22'((1 << 21) | (2 << 16) | (5 << 11) | (1 << 10) | (4 << 5) | 3);
        write_word(1'b1, w); select(1'b1);
        cycle(w, 1'b0, "R5 extension PIO");
        cycle(w, 1'b1, "R5 extension ignored DMA");
        // R6 zero counts
        write_word(1'b1, 22'h0); select(1'b1);
        cycle(22'h0, 1'b0, "R6 zero PIO");
        cycle(22'h0, 1'b1, "R6 zero DMA");

        // R7 write without select keeps active word
        w0 = 22'((5 << 5) | 9);
        w1 = 22'((2 << 5) | 1);
        write_word(1'b0, w0); select(1'b0);
        write_word(1'b0, w1);
        cycle(w0, 1'b0, "R7 write without select");
        select(1'b0);
        cycle(w1, 1'b0, "R7 select loads slot");
        // R7 same-clock write and select
        w = 22'((3 << 5) | 2);
        @(negedge clk); cfg_we_i = 1'b1; cfg_dev_i = 1'b1; cfg_word_i = w; sel_i = 1'b1; sel_dev_i = 1'b1;
        @(negedge clk); cfg_we_i = 1'b0; sel_i = 1'b0;
        cycle(w, 1'b0, "R7 forwarded write");

        // R8 select during cycle
        w0 = 22'((6 << 5) | 8);
        w1 = 22'((1 << 5) | 2);
        write_word(1'b0, w0); write_word(1'b1, w1); select(1'b0);
        exp_len(w0, 1'b0, a, r);
        @(negedge clk); req_i = 1'b1; dma_i = 1'b0;
        @(negedge clk); req_i = 1'b0; sel_i = 1'b1; sel_dev_i = 1'b1;
        @(negedge clk); sel_i = 1'b0;
        measure(a, r, 1, "R8 mid-cycle select");
        cycle(w1, 1'b0, "R8 next cycle uses new word");

        // R10 held request
        w = 22'((4 << 16) | (2 << 11) | (3 << 5) | 5);
        write_word(1'b0, w); select(1'b0);
        exp_len(w, 1'b0, a, r); exp_len(w, 1'b1, a2, r2);
        @(negedge clk); req_i = 1'b1; dma_i = 1'b0;
        @(negedge clk); req_i = 1'b0;
        hi = 0;
        while (strobe_o && hi < 400) begin hi++; @(negedge clk); end
        chk(hi == a, "R10 first access", hi, a);
        req_i = 1'b1; dma_i = 1'b1;
        @(negedge clk); req_i = 1'b0; dma_i = 1'b0;
        lo = 1;
        while (!done_o && lo < 400) begin lo++; @(negedge clk); end
        chk(lo == r, "R10 first recovery", lo, r);
        chk(strobe_o && busy_o, "R10 held cycle starts at done", strobe_o, 1);
        measure(a2, r2, 0, "R10 held DMA cycle");

        // R1 wake
        write_word(1'b0, 22'h3);
        write_word(1'b1, 22'h5);
        @(negedge clk); wake_i = 1'b1;
        @(negedge clk); wake_i = 1'b0;
        cycle(22'h074526, 1'b1, "R1 wake active default");
        select(1'b1);
        cycle(22'h074526, 1'b0, "R1 wake slot default");
        // R1 wake aborts cycle
        issue(1'b0);
        @(negedge clk); wake_i = 1'b1;
        @(negedge clk); wake_i = 1'b0;
        chk(!strobe_o && !busy_o, "R1 wake aborts cycle", {strobe_o, busy_o}, 0);

        // random mix
        for (int i = 0; i < 25; i++) begin
            bit dev;
            w   = 22'($urandom);
            dev = 1'($urandom);
            write_word(dev, w); select(dev);
            cycle(w, 1'b0, "R2 random PIO");
            cycle(w, 1'b1, "R3 random DMA");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule